// File: doc/BRIEF.md
# Frame Buffer Stream Readout

This block holds one processed grayscale frame and hands it to a stream-to-memory DMA engine. A compute array writes pixels into an internal dual-port buffer through a plain write port: one pixel per cycle, at any address, at any time. When the array pulses its frame-finished input, the readout engine walks the buffer from address zero upward. It presents one 8-bit pixel per AXI4-Stream beat and marks the final pixel of the frame with TLAST. The DMA can therefore move the whole frame with no processor work per pixel.

Software controls the block through a small AXI4-Lite register set. One bit arms automatic readout on frame completion. A second bit is a self-clearing soft reset. Software can read a busy flag, a sticky frame-sent flag, a sticky overrun flag and a count of frames delivered. A frame-finished pulse that arrives while a readout is still in progress does not restart or disturb that readout; it only raises the overrun flag. Frame geometry is set by parameters: a 320 x 240 configuration gives 76,800 beats per frame, and the defaults are smaller.

Top module: `fbuf_stream_top`

## Requirements
- R1: After reset, TVALID is low and the registers read zero: control at offset 0x0, status at 0x4 and frame count at 0x8. Every AXI4-Lite response is OKAY (2'b00).
- R2: A frame-finished pulse starts a readout only when control bit0 (auto-start) is 1 and no readout is in progress. With control bit0 at 0, the pulse has no effect: TVALID stays low and busy stays 0.
- R3: Pixels leave in ascending buffer address order, starting at address 0. Each beat carries exactly one pixel in TDATA[7:0], and a frame has exactly FRAME_W*FRAME_H beats.
- R4: TLAST is 1 on the final beat of a frame (address FRAME_W*FRAME_H-1) and 0 on every other beat.
- R5: While TVALID is 1 and TREADY is 0, TVALID, TDATA and TLAST hold steady. Any TREADY pattern delivers each pixel exactly once.
- R6: Status bit0 (busy) is 1 from the cycle after a readout starts until the final beat is accepted. TVALID is never 1 while busy is 0.
- R7: Status bit1 (frame sent) sets when the final beat is accepted. Writing 1 to status bit1 clears it, and writing 0 leaves it set.
- R8: A frame-finished pulse while busy is 1 sets status bit2 (overrun, write-1-to-clear). The running readout continues unchanged, and no extra frame follows it.
- R9: The frame count at 0x8 increases by one for each completed frame. Writes to it have no effect.
- R10: Writing 1 to control bit1 aborts any readout: TVALID drops and busy clears. It also zeroes the frame-sent flag, the overrun flag and the frame count. Control bit0 keeps its value and bit1 always reads 0. The next readout starts again at address 0.
- R11: If a frame-finished pulse is sampled on a clock edge and starts a readout, TVALID rises right after the second edge that follows it, even while TREADY is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_we | input | 1 | Pixel write enable from the compute array |
| pix_waddr | input | ADDR_W | Pixel write address |
| pix_wdata | input | 8 | Pixel write data |
| frame_done | input | 1 | One-cycle pulse: the frame in the buffer is complete |
| s_awaddr | input | 4 | AXI4-Lite write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_tdata | output | 8 | Stream pixel |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final beat of frame |

## Verification
A readout starts on the edge that samples frame_done, so busy is already set after that edge. The first buffer read registers on the next edge, and TVALID appears after the second edge. The bench samples TVALID low after the first edge and high after the second, with TREADY held low.

Stream beats are taken on negative edges: a beat counts as accepted when TVALID and TREADY are both high there, and the following positive edge completes it. A held beat is compared at the next negative edge. A register write takes effect on its handshake edge, and a soft reset acts one edge later, so the bench waits several cycles before it reads back. Register reads return data one edge after the address handshake, and that is where the bench captures them.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int PIX_W  = 8;
    localparam int REG_DW = 32;
    localparam int REG_AW = 4;

    localparam int CTRL_AUTO = 0;
    localparam int CTRL_SRST = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_SENT = 1;
    localparam int STAT_OVR  = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_FCNT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic             last;
        logic [PIX_W-1:0] data;
    } beat_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] word);
        return reg_sel_e'(word);
    endfunction

endpackage

// File: rtl/fbs_pixel_ram.sv
module fbs_pixel_ram
    import fbs_pkg::*;
#(
    parameter int DEPTH = 768,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [PIX_W-1:0] rd_data
);

    logic [PIX_W-1:0] mem [DEPTH];

    // Both ports update on the same edge; the read port returns the
    // word held before any write on that edge (read-first).
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/fbs_stream_reader.sv
module fbs_stream_reader
    import fbs_pkg::*;
#(
    parameter int TOTAL = 768,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             start,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [PIX_W-1:0] rd_data,
    output logic [PIX_W-1:0] tdata,
    output logic             tvalid,
    output logic             tlast,
    input  logic             tready,
    output logic             busy,
    output logic             done_evt
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(TOTAL - 1);

    rd_state_e   state_q;
    logic [AW-1:0] addr_q;
    logic        issued_all_q;
    logic        pend_q;
    logic        pend_last_q;
    logic [1:0]  occ_q;
    beat_t       head_q;
    beat_t       skid_q;

    logic  pop;
    logic  push;
    logic  issue;
    logic [2:0] load;
    beat_t incoming;

    assign pop      = (occ_q != 2'd0) && tready;
    assign push     = pend_q;
    assign load     = {1'b0, occ_q} + {2'b00, pend_q};
    assign issue    = (state_q == RD_RUN) && !issued_all_q &&
                      ((load <= 3'd1) || ((load == 3'd2) && pop));
    assign incoming = '{last: pend_last_q, data: rd_data};

    assign rd_en    = issue;
    assign rd_addr  = addr_q;
    assign tvalid   = (occ_q != 2'd0);
    assign tdata    = head_q.data;
    assign tlast    = head_q.last;
    assign busy     = (state_q == RD_RUN);
    assign done_evt = pop && head_q.last;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q      <= RD_IDLE;
            addr_q       <= '0;
            issued_all_q <= 1'b0;
            pend_q       <= 1'b0;
            pend_last_q  <= 1'b0;
            occ_q        <= 2'd0;
            head_q       <= '0;
            skid_q       <= '0;
        end else begin
            if (start && (state_q == RD_IDLE)) begin
                state_q      <= RD_RUN;
                addr_q       <= '0;
                issued_all_q <= 1'b0;
            end else if (done_evt) begin
                state_q <= RD_IDLE;
            end

            if (issue) begin
                addr_q <= addr_q + AW'(1);
                if (addr_q == LAST_ADDR) begin
                    issued_all_q <= 1'b1;
                end
            end
            pend_q      <= issue;
            pend_last_q <= issue && (addr_q == LAST_ADDR);

            case ({push, pop})
                2'b10: begin
                    if (occ_q == 2'd0) head_q <= incoming;
                    else               skid_q <= incoming;
                    occ_q <= occ_q + 2'd1;
                end
                2'b01: begin
                    if (occ_q == 2'd2) head_q <= skid_q;
                    occ_q <= occ_q - 2'd1;
                end
                2'b11: begin
                    if (occ_q == 2'd1) begin
                        head_q <= incoming;
                    end else begin
                        head_q <= skid_q;
                        skid_q <= incoming;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fbs_axil_regs.sv
module fbs_axil_regs
    import fbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [REG_DW-1:0] s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [REG_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [REG_DW-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              busy,
    input  logic              frame_evt,
    input  logic              ovr_evt,
    output logic              auto_en,
    output logic              soft_rst
);

    logic              sent_q;
    logic              ovr_q;
    logic [REG_DW-1:0] fcnt_q;
    logic              wr_fire;
    logic              rd_fire;
    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic              unused_bits;

    assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[REG_DW-1:3]};

    assign wr_fire   = s_awvalid && s_wvalid && !s_bvalid;
    assign rd_fire   = s_arvalid && !s_rvalid;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_arready = !s_rvalid;
    assign s_bresp   = 2'b00;
    assign s_rresp   = 2'b00;
    assign wsel      = decode_sel(s_awaddr[3:2]);
    assign rsel      = decode_sel(s_araddr[3:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en  <= 1'b0;
            soft_rst <= 1'b0;
            sent_q   <= 1'b0;
            ovr_q    <= 1'b0;
            fcnt_q   <= '0;
            s_bvalid <= 1'b0;
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else begin
            soft_rst <= wr_fire && (wsel == SEL_CTRL) && s_wdata[CTRL_SRST];
            if (wr_fire && (wsel == SEL_CTRL)) begin
                auto_en <= s_wdata[CTRL_AUTO];
            end

            if (soft_rst)       sent_q <= 1'b0;
            else if (frame_evt) sent_q <= 1'b1;
            else if (wr_fire && (wsel == SEL_STAT) && s_wdata[STAT_SENT]) sent_q <= 1'b0;

            if (soft_rst)       ovr_q <= 1'b0;
            else if (ovr_evt)   ovr_q <= 1'b1;
            else if (wr_fire && (wsel == SEL_STAT) && s_wdata[STAT_OVR]) ovr_q <= 1'b0;

            if (soft_rst)       fcnt_q <= '0;
            else if (frame_evt) fcnt_q <= fcnt_q + REG_DW'(1);

            if (wr_fire)       s_bvalid <= 1'b1;
            else if (s_bready) s_bvalid <= 1'b0;

            if (rd_fire) begin
                s_rvalid <= 1'b1;
                case (rsel)
                    SEL_CTRL: s_rdata <= REG_DW'(auto_en);
                    SEL_STAT: s_rdata <= REG_DW'({ovr_q, sent_q, busy});
                    SEL_FCNT: s_rdata <= fcnt_q;
                    default:  s_rdata <= '0;
                endcase
            end else if (s_rready) begin
                s_rvalid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fbuf_stream_top.sv
module fbuf_stream_top
    import fbs_pkg::*;
#(
    parameter  int FRAME_W = 32,
    parameter  int FRAME_H = 24,
    localparam int TOTAL   = FRAME_W * FRAME_H,
    localparam int ADDR_W  = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_we,
    input  logic [ADDR_W-1:0] pix_waddr,
    input  logic [7:0]        pix_wdata,
    input  logic              frame_done,
    input  logic [3:0]        s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [3:0]        s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [7:0]        m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);

    logic              auto_en;
    logic              soft_rst;
    logic              busy;
    logic              done_evt;
    logic              start;
    logic              ovr_evt;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [PIX_W-1:0]  rd_data;

    assign start   = frame_done && auto_en && !busy;
    assign ovr_evt = frame_done && busy;

    fbs_pixel_ram #(.DEPTH(TOTAL), .AW(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (pix_we),
        .wr_addr (pix_waddr),
        .wr_data (pix_wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    fbs_stream_reader #(.TOTAL(TOTAL), .AW(ADDR_W)) u_reader (
        .clk      (clk),
        .clr      (rst || soft_rst),
        .start    (start),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tdata    (m_tdata),
        .tvalid   (m_tvalid),
        .tlast    (m_tlast),
        .tready   (m_tready),
        .busy     (busy),
        .done_evt (done_evt)
    );

    fbs_axil_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .busy      (busy),
        .frame_evt (done_evt),
        .ovr_evt   (ovr_evt),
        .auto_en   (auto_en),
        .soft_rst  (soft_rst)
    );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
    parameter int TOTAL = 768
) (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       frame_done,
    input logic       auto_en,
    input logic       busy,
    input logic       ovr_flag,
    input logic       sent_flag,
    input logic       tvalid,
    input logic       tready,
    input logic [7:0] tdata,
    input logic       tlast
);

    logic [31:0] beat_cnt;
    logic        pop;

    assign pop = tvalid && tready;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)  beat_cnt <= '0;
        else if (pop)         beat_cnt <= tlast ? 32'd0 : beat_cnt + 32'd1;
    end

    // R5: a stalled beat keeps its payload
    a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    // R2: armed pulse while idle starts a readout
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (frame_done && auto_en && !busy) |=> busy);

    // R2: disarmed pulse leaves the block idle
    a_r2_disarmed_idle: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (frame_done && !auto_en && !busy) |=> !busy);

    // R8: pulse during readout raises overrun
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (frame_done && busy) |=> ovr_flag);

    // R4: TLAST marks exactly the final beat
    a_r4_last_position: assert property (@(posedge clk) disable iff (rst || soft_rst)
        pop |-> (tlast == (beat_cnt == 32'(TOTAL - 1))));

    // R6: no stream traffic while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst || soft_rst)
        !busy |-> !tvalid);

    // R7: final beat ends the readout and flags it sent
    a_r7_sent_set: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (pop && tlast) |=> (!busy && sent_flag));

endmodule

bind fbuf_stream_top fbs_checker #(.TOTAL(TOTAL)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .frame_done (frame_done),
    .auto_en    (auto_en),
    .busy       (busy),
    .ovr_flag   (u_regs.ovr_q),
    .sent_flag  (u_regs.sent_q),
    .tvalid     (m_tvalid),
    .tready     (m_tready),
    .tdata      (m_tdata),
    .tlast      (m_tlast)
);

// File: tb/fbuf_stream_top_tb_top.sv
module fbuf_stream_top_tb_top;

    localparam int FW    = 16;
    localparam int FH    = 4;
    localparam int TOTAL = FW * FH;
    localparam int AW    = $clog2(TOTAL);

    logic          clk = 1'b0;
    logic          rst;
    logic          pix_we;
    logic [AW-1:0] pix_waddr;
    logic [7:0]    pix_wdata;
    logic          frame_done;
    logic [3:0]    s_awaddr;
    logic          s_awvalid;
    logic          s_awready;
    logic [31:0]   s_wdata;
    logic          s_wvalid;
    logic          s_wready;
    logic [1:0]    s_bresp;
    logic          s_bvalid;
    logic          s_bready;
    logic [3:0]    s_araddr;
    logic          s_arvalid;
    logic          s_arready;
    logic [31:0]   s_rdata;
    logic [1:0]    s_rresp;
    logic          s_rvalid;
    logic          s_rready;
    logic [7:0]    m_tdata;
    logic          m_tvalid;
    logic          m_tready;
    logic          m_tlast;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    fbuf_stream_top #(.FRAME_W(FW), .FRAME_H(FH)) dut_i (
        .clk(clk), .rst(rst),
        .pix_we(pix_we), .pix_waddr(pix_waddr), .pix_wdata(pix_wdata),
        .frame_done(frame_done),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    function automatic logic [7:0] pix(input int seed, input int a);
        return 8'((a * 37 + seed * 11 + (a >> 3)) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < TOTAL; a++) begin
            @(negedge clk);
            pix_we = 1'b1; pix_waddr = AW'(a); pix_wdata = pix(seed, a);
        end
        @(negedge clk);
        pix_we = 1'b0;
    endtask

    task automatic axil_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic axil_read(input logic [3:0] a, output logic [31:0] d, output logic [1:0] rr);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        d = s_rdata; rr = s_rresp;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    // mode 0: always ready, 1: ready one cycle in three, 2: pseudo-random
    task automatic collect(input int mode, input int stop_after, input int ovr_at,
                           input int seed, output int got, output int bad_data,
                           output int bad_last, output int bad_stall);
        int idle = 0;
        int cyc = 0;
        bit held = 1'b0;
        bit ovr_sent = 1'b0;
        logic [7:0] hd = '0;
        logic hl = 1'b0;
        logic rdy;
        got = 0; bad_data = 0; bad_last = 0; bad_stall = 0;
        while (got < stop_after && idle < 200) begin
            @(negedge clk);
            frame_done = 1'b0;
            if (ovr_at >= 0 && !ovr_sent && got >= ovr_at) begin
                frame_done = 1'b1;
                ovr_sent = 1'b1;
            end
            if (held) begin
                if (!m_tvalid || m_tdata != hd || m_tlast != hl) bad_stall++;
                held = 1'b0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (mode)
                0:       rdy = 1'b1;
                1:       rdy = (cyc % 3 == 2);
                default: rdy = lfsr[0];
            endcase
            m_tready = rdy;
            if (m_tvalid) begin
                idle = 0;
                if (rdy) begin
                    if (m_tdata != pix(seed, got)) bad_data++;
                    if (m_tlast != (got == TOTAL - 1)) bad_last++;
                    got++;
                end else begin
                    held = 1'b1; hd = m_tdata; hl = m_tlast;
                end
            end else begin
                idle++;
            end
            cyc++;
        end
        @(negedge clk);
        m_tready = 1'b0;
        frame_done = 1'b0;
    endtask

    task automatic check_frame(input string tag, input int got, input int bd,
                               input int bl, input int bs);
        check(got == TOTAL, tag, "beats per frame", got, TOTAL);
        check(bd == 0, "R3", "pixel order mismatches", bd, 0);
        check(bl == 0, "R4", "misplaced TLAST", bl, 0);
        check(bs == 0, "R5", "stall payload changes", bs, 0);
    endtask

    task automatic quiet_for(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_tvalid) seen++;
        end
        check(seen == 0, tag, "TVALID cycles while expected idle", seen, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] rr;
        check(m_tvalid == 1'b0, "R1", "TVALID after reset", int'(m_tvalid), 0);
        axil_read(4'h0, d, rr);
        check(d == 0, "R1", "control after reset", int'(d), 0);
        check(rr == 2'b00, "R1", "read response", int'(rr), 0);
        axil_read(4'h4, d, rr);
        check(d == 0, "R1", "status after reset", int'(d), 0);
        axil_read(4'h8, d, rr);
        check(d == 0, "R1", "frame count after reset", int'(d), 0);
    endtask

    task automatic t_disarmed();
        logic [31:0] d; logic [1:0] rr;
        fill(1);
        pulse_done();
        quiet_for(10, "R2");
        axil_read(4'h4, d, rr);
        check(d[0] == 1'b0, "R2", "busy after disarmed pulse", int'(d[0]), 0);
    endtask

    task automatic t_basic();
        logic [31:0] d; logic [1:0] rr;
        int got, bd, bl, bs;
        axil_write(4'h0, 32'h1);
        check(s_bresp == 2'b00, "R1", "write response", int'(s_bresp), 0);
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(m_tvalid == 1'b0, "R11", "TVALID one edge after start", int'(m_tvalid), 0);
        @(negedge clk);
        check(m_tvalid == 1'b0, "R11", "TVALID after first read edge", int'(m_tvalid), 0);
        @(negedge clk);
        check(m_tvalid == 1'b1, "R11", "TVALID after second edge", int'(m_tvalid), 1);
        axil_read(4'h4, d, rr);
        check(d[0] == 1'b1, "R6", "busy during readout", int'(d[0]), 1);
        collect(0, TOTAL, -1, 1, got, bd, bl, bs);
        check_frame("R3", got, bd, bl, bs);
        quiet_for(5, "R6");
        axil_read(4'h4, d, rr);
        check(d[2:0] == 3'b010, "R7", "status after frame", int'(d[2:0]), 2);
        axil_read(4'h8, d, rr);
        check(d == 1, "R9", "frame count", int'(d), 1);
    endtask

    task automatic t_w1c();
        logic [31:0] d; logic [1:0] rr;
        axil_write(4'h4, 32'h0);
        axil_read(4'h4, d, rr);
        check(d[1] == 1'b1, "R7", "sent after writing 0", int'(d[1]), 1);
        axil_write(4'h4, 32'h2);
        axil_read(4'h4, d, rr);
        check(d[1] == 1'b0, "R7", "sent after writing 1", int'(d[1]), 0);
        axil_write(4'h8, 32'h5);
        axil_read(4'h8, d, rr);
        check(d == 1, "R9", "count after write attempt", int'(d), 1);
    endtask

    task automatic t_backpressure();
        logic [31:0] d; logic [1:0] rr;
        int got, bd, bl, bs;
        fill(2);
        pulse_done();
        collect(1, TOTAL, -1, 2, got, bd, bl, bs);
        check_frame("R5", got, bd, bl, bs);
        fill(3);
        pulse_done();
        collect(2, TOTAL, -1, 3, got, bd, bl, bs);
        check_frame("R5", got, bd, bl, bs);
        axil_read(4'h8, d, rr);
        check(d == 3, "R9", "count after three frames", int'(d), 3);
    endtask

    task automatic t_overrun();
        logic [31:0] d; logic [1:0] rr;
        int got, bd, bl, bs;
        fill(4);
        pulse_done();
        collect(2, TOTAL, 10, 4, got, bd, bl, bs);
        check_frame("R8", got, bd, bl, bs);
        quiet_for(12, "R8");
        axil_read(4'h4, d, rr);
        check(d[2:0] == 3'b110, "R8", "status after overrun", int'(d[2:0]), 6);
        axil_read(4'h8, d, rr);
        check(d == 4, "R8", "count after overrun frame", int'(d), 4);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d; logic [1:0] rr;
        int got, bd, bl, bs;
        fill(5);
        pulse_done();
        collect(0, 20, -1, 5, got, bd, bl, bs);
        check(bd == 0 && got == 20, "R10", "partial frame before abort", got, 20);
        axil_write(4'h0, 32'h3);
        quiet_for(4, "R10");
        axil_read(4'h4, d, rr);
        check(d[2:0] == 3'b000, "R10", "status after soft reset", int'(d[2:0]), 0);
        axil_read(4'h8, d, rr);
        check(d == 0, "R10", "count after soft reset", int'(d), 0);
        axil_read(4'h0, d, rr);
        check(d == 1, "R10", "control after soft reset", int'(d), 1);
        pulse_done();
        collect(0, TOTAL, -1, 5, got, bd, bl, bs);
        check_frame("R10", got, bd, bl, bs);
        axil_read(4'h8, d, rr);
        check(d == 1, "R10", "count after restart", int'(d), 1);
    endtask

    initial begin
        rst = 1'b1; pix_we = 1'b0; pix_waddr = '0; pix_wdata = '0; frame_done = 1'b0;
        s_awaddr = '0; s_awvalid = 1'b0; s_wdata = '0; s_wvalid = 1'b0; s_bready = 1'b1;
        s_araddr = '0; s_arvalid = 1'b0; s_rready = 1'b1; m_tready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disarmed();
        t_basic();
        t_w1c();
        t_backpressure();
        t_overrun();
        t_soft_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule